// File: doc/BRIEF.md
# Streaming Dual-Chain Fletcher Checksum Engine

The engine folds a byte stream into a 256-bit Fletcher-style checksum. Data arrives as 16-byte beats over a valid/ready handshake. Each beat is cut into two 64-bit words. The first word feeds one running-sum chain and the second word feeds another. Each chain keeps a first-order sum and a second-order sum of that first-order sum. Every addition wraps modulo 2^64, and no modulus or end-around carry is applied.

A one-cycle `start` clears all four sums and latches the byte order used to assemble words for the new message. A beat offered in the same cycle as `start` is the first beat of the new message. The final beat of a message is flagged by `in_last` and carries a byte count. A short final beat is dropped, not padded. One clock after the final beat is taken, `done` pulses for one cycle. The four sums then stay frozen until the next `start`.

The controller has three states:
- `ST_RUN`: beats are accepted and accumulated.
- `ST_DONE`: the `done` pulse; the engine is not ready.
- `ST_HOLD`: the result is frozen; beats are accepted but discarded.

Its transitions:
- RUN→DONE on an accepted last beat.
- DONE→HOLD when there is no start.
- DONE→RUN on start.
- HOLD→RUN on start.
- HOLD→DONE on start together with an accepted last beat.

Top module: `fletcher_stream`

## Requirements
- R1: Byte k of a beat sits at `in_data[8k+7:8k]`. The first word is taken from bytes 0 to 7 and the second word from bytes 8 to 15.
- R2: For each accumulated beat, with first word v and second word w, the sums update in this order: `sum_a += v`, `sum_b += w`, then `sum_c += ` the new `sum_a`, and `sum_d += ` the new `sum_b`. Updated sums appear on the ports one clock after the beat is taken.
- R3: All four sums wrap modulo 2^64, with no carry fold-back.
- R4: Byte order is taken from `order_big` only in a cycle with `start`.
  - With 1, byte 0 of each word group is the most significant byte.
  - With 0, byte 0 is the least significant byte.
- R5: After reset:
  - all sums are zero;
  - `done` is 0 and `in_ready` is 1;
  - the byte order is little-endian (0) until a `start`.
- R6: `start` zeroes the sums one clock later. A beat accepted in the same cycle as `start` is accumulated as the first beat of the new message, using the newly latched byte order.
- R7: Non-last beats are always complete. A last beat with `in_bytes` below 16 adds nothing; with `in_bytes` of 16 it is accumulated.
- R8: `done` is high for exactly one cycle, one clock after a last beat is accepted in a running message. The sums on that cycle are the final result.
- R9: `in_ready` is low only in the `done` cycle, so beats may be taken in every other cycle.
- R10: After `done` and until the next `start`:
  - the sums hold their values;
  - beats are accepted and discarded;
  - no further `done` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a message: clear sums, latch byte order |
| order_big | input | 1 | Byte order sampled with start (1 = byte 0 most significant) |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_data | input | 128 | Beat bytes, byte k at bits 8k+7:8k |
| in_last | input | 1 | Beat is the last of the message |
| in_bytes | input | 5 | Valid byte count of a last beat (16 = complete) |
| done | output | 1 | One-cycle completion pulse |
| sum_a | output | 64 | First-order sum of first words |
| sum_b | output | 64 | First-order sum of second words |
| sum_c | output | 64 | Second-order sum of the first chain |
| sum_d | output | 64 | Second-order sum of the second chain |

## Verification
Every result in this block is due exactly one clock after the edge that accepts its beat or `start`. This covers the sums, `done` and the return of `in_ready`. A behavioural model steps on each rising edge from the same inputs. The design outputs are compared with that model on the following falling edge, so each comparison sees the state one register after the stimulus. Directed checks are likewise taken at the falling edge right after the accepting edge. For held results and ignored beats, they are also taken on later idle cycles.

// File: rtl/fse_pkg.sv
package fse_pkg;
    localparam int unsigned FSE_LANES = 2;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_DONE = 2'd1,
        ST_HOLD = 2'd2
    } fse_state_e;
endpackage

// File: rtl/fse_unpack.sv
module fse_unpack #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned LANES  = 2
) (
    input  logic [LANES*WORD_W-1:0]       beat,
    input  logic                          big,
    output logic [LANES-1:0][WORD_W-1:0]  words
);
    localparam int unsigned NB = WORD_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar k = 0; k < NB; k++) begin : g_byte
            assign words[l][8*k +: 8] = big ? beat[8*(l*NB + NB - 1 - k) +: 8]
                                            : beat[8*(l*NB + k) +: 8];
        end
    end
endmodule

// File: rtl/fse_lane.sv
module fse_lane #(
    parameter int unsigned WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] first,
    output logic [WORD_W-1:0] second
);
    logic [WORD_W-1:0] base1, base2, nxt1, nxt2;

    always_comb begin
        base1 = clear ? '0 : first;
        base2 = clear ? '0 : second;
        nxt1  = base1 + word;
        nxt2  = base2 + nxt1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first  <= '0;
            second <= '0;
        end else if (add) begin
            first  <= nxt1;
            second <= nxt2;
        end else if (clear) begin
            first  <= '0;
            second <= '0;
        end
    end
endmodule

// File: rtl/fse_ctrl.sv
module fse_ctrl
    import fse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic in_last,
    input  logic in_full,
    output logic in_ready,
    output logic done,
    output logic lane_clear,
    output logic lane_add
);
    fse_state_e state, state_nxt;
    logic take, active;

    assign take   = in_valid && in_ready;
    assign active = start || (state == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:  if (take && in_last) state_nxt = ST_DONE;
            ST_DONE: state_nxt = start ? ST_RUN : ST_HOLD;
            ST_HOLD: if (start) state_nxt = (take && in_last) ? ST_DONE : ST_RUN;
            default: state_nxt = ST_RUN;
        endcase
    end

    always_comb begin
        in_ready   = (state != ST_DONE);
        done       = (state == ST_DONE);
        lane_clear = start;
        lane_add   = in_valid && (state != ST_DONE) && active && (!in_last || in_full);
    end
endmodule

// File: rtl/fletcher_stream.sv
module fletcher_stream
    import fse_pkg::*;
#(
    parameter int unsigned WORD_W = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        order_big,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [2*WORD_W-1:0]         in_data,
    input  logic                        in_last,
    input  logic [$clog2(WORD_W/4+1)-1:0] in_bytes,
    output logic                        done,
    output logic [WORD_W-1:0]           sum_a,
    output logic [WORD_W-1:0]           sum_b,
    output logic [WORD_W-1:0]           sum_c,
    output logic [WORD_W-1:0]           sum_d
);
    localparam int unsigned BEAT_BYTES = FSE_LANES * WORD_W / 8;
    localparam int unsigned CNT_W      = $clog2(WORD_W/4+1);

    logic order_q, order_eff, in_full, lane_clear, lane_add;
    logic [FSE_LANES-1:0][WORD_W-1:0] words, first_s, second_s;

    assign order_eff = start ? order_big : order_q;
    assign in_full   = (in_bytes >= CNT_W'(BEAT_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     order_q <= 1'b0;
        else if (start) order_q <= order_big;
    end

    fse_unpack #(.WORD_W(WORD_W), .LANES(FSE_LANES)) u_unpack (
        .beat  (in_data),
        .big   (order_eff),
        .words (words)
    );

    fse_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_full    (in_full),
        .in_ready   (in_ready),
        .done       (done),
        .lane_clear (lane_clear),
        .lane_add   (lane_add)
    );

    for (genvar l = 0; l < FSE_LANES; l++) begin : g_chain
        fse_lane #(.WORD_W(WORD_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (lane_clear),
            .add    (lane_add),
            .word   (words[l]),
            .first  (first_s[l]),
            .second (second_s[l])
        );
    end

    assign sum_a = first_s[0];
    assign sum_b = first_s[1];
    assign sum_c = second_s[0];
    assign sum_d = second_s[1];
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
    parameter int unsigned WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic              done,
    input logic [WORD_W-1:0] sum_a,
    input logic [WORD_W-1:0] sum_b,
    input logic [WORD_W-1:0] sum_c,
    input logic [WORD_W-1:0] sum_d
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     armed <= 1'b1;
        else if (start) armed <= 1'b1;
        else if (done)  armed <= 1'b0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && (armed || start)) |=> done); // R8
    AST_DONE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_ready && in_last)); // R8
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((!armed || done) && !start) |=> ($stable(sum_a) && $stable(sum_b) && $stable(sum_c) && $stable(sum_d))); // R10
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !(in_valid && in_ready)) |=> (sum_a == '0 && sum_b == '0 && sum_c == '0 && sum_d == '0)); // R6
endmodule

bind fletcher_stream fse_checker #(.WORD_W(WORD_W)) u_fse_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .done     (done),
    .sum_a    (sum_a),
    .sum_b    (sum_b),
    .sum_c    (sum_c),
    .sum_d    (sum_d)
);

// File: tb/test_fletcher_stream.sv
module test_fletcher_stream;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         order_big = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         in_last = 1'b0;
    logic [4:0]   in_bytes = 5'd16;
    logic         done;
    logic [63:0]  sum_a, sum_b, sum_c, sum_d;

    int errors = 0;
    int checks = 0;
    bit model_on = 1'b0;

    fletcher_stream i_fletcher_stream (
        .clk(clk), .rst_n(rst_n), .start(start), .order_big(order_big),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_bytes(in_bytes), .done(done),
        .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    longint unsigned m_a, m_b, m_c, m_d, mv, mw;
    bit m_big, m_fire, m_act;
    int m_phase; // 0 running, 1 done cycle, 2 holding

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_c = 0; m_d = 0; m_big = 0; m_phase = 0;
        end else begin
            m_fire = in_valid && (m_phase != 1);
            m_act  = start || (m_phase == 0);
            if (start) begin
                m_a = 0; m_b = 0; m_c = 0; m_d = 0; m_big = order_big;
            end
            mv = 0; mw = 0;
            for (int k = 0; k < 8; k++) begin
                if (m_big) begin
                    mv = (mv << 8) | longint'(in_data[8*k +: 8]);
                    mw = (mw << 8) | longint'(in_data[64 + 8*k +: 8]);
                end else begin
                    mv = mv | (longint'(in_data[8*k +: 8]) << (8*k));
                    mw = mw | (longint'(in_data[64 + 8*k +: 8]) << (8*k));
                end
            end
            if (m_fire && m_act && (!in_last || in_bytes >= 16)) begin
                m_a = m_a + mv; m_b = m_b + mw; m_c = m_c + m_a; m_d = m_d + m_b;
            end
            if (m_fire && m_act && in_last) m_phase = 1;
            else if (start)                 m_phase = 0;
            else if (m_phase == 1)          m_phase = 2;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            chk("R2 model sum_a", sum_a, m_a);
            chk("R2 model sum_b", sum_b, m_b);
            chk("R3 model sum_c", sum_c, m_c);
            chk("R3 model sum_d", sum_d, m_d);
            chk("R8 model done", 64'(done), 64'(m_phase == 1));
            chk("R9 model in_ready", 64'(in_ready), 64'(m_phase != 1));
        end
    end

    function automatic logic [127:0] le(input logic [63:0] v, input logic [63:0] w);
        return {w, v};
    endfunction

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic send(input logic [127:0] d, input logic last, input logic [4:0] nb,
                        input logic st, input logic ob);
        in_valid = 1'b1; in_data = d; in_last = last; in_bytes = nb;
        start = st; order_big = ob;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
        @(negedge clk);
    endtask

    task automatic sums(input string req, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, input logic [63:0] d);
        chk(req, sum_a, a); chk(req, sum_b, b); chk(req, sum_c, c); chk(req, sum_d, d);
    endtask

    logic [127:0] ramp;

    initial begin
        for (int k = 0; k < 16; k++) ramp[8*k +: 8] = 8'(k + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1'b1;
        sums("R5 reset sums", 0, 0, 0, 0);
        chk("R5 reset done", 64'(done), 0);
        chk("R5 reset ready", 64'(in_ready), 1);

        // R4/R5: order_big not latched without start -> little-endian; R1 byte split
        send(ramp, 1, 16, 0, 1);
        sums("R1 little ramp", 64'h0807060504030201, 64'h100F0E0D0C0B0A09,
             64'h0807060504030201, 64'h100F0E0D0C0B0A09);
        chk("R8 done after last", 64'(done), 1);
        chk("R9 ready low in done", 64'(in_ready), 0);
        idle();
        chk("R8 done one cycle", 64'(done), 0);

        // R4/R6: start in hold with beat, big-endian
        send(ramp, 1, 16, 1, 1);
        sums("R4 big ramp", 64'h0102030405060708, 64'h090A0B0C0D0E0F10,
             64'h0102030405060708, 64'h090A0B0C0D0E0F10);
        idle();

        // R2/R9: back-to-back beats
        send(le(64'd1, 64'd2), 0, 16, 1, 0);
        chk("R9 ready between beats", 64'(in_ready), 1);
        send(le(64'd3, 64'd5), 1, 16, 0, 0);
        sums("R2 order of updates", 64'd4, 64'd7, 64'd5, 64'd9);
        idle();

        // R3: wrap
        send(le(64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000), 0, 16, 1, 0);
        send(le(64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000), 1, 16, 0, 0);
        sums("R3 wrap", 64'hFFFFFFFFFFFFFFFE, 64'h0, 64'hFFFFFFFFFFFFFFFD, 64'h8000000000000000);
        idle();

        // R7: short last beat discarded
        send(le(64'd1, 64'd1), 0, 16, 1, 0);
        send(le(64'd100, 64'd100), 1, 15, 0, 0);
        sums("R7 short last dropped", 1, 1, 1, 1);
        chk("R7 done on short last", 64'(done), 1);
        idle();

        // R10: beats after done are discarded, result held
        send(le(64'd7, 64'd7), 1, 16, 0, 0);
        sums("R10 beat after done ignored", 1, 1, 1, 1);
        chk("R10 no second done", 64'(done), 0);
        idle(); idle();
        sums("R10 result held", 1, 1, 1, 1);

        // R6: start alone clears; then start with a beat
        start = 1'b1; @(negedge clk); start = 1'b0;
        sums("R6 start clears", 0, 0, 0, 0);
        send(le(64'd9, 64'd4), 1, 16, 1, 0);
        sums("R6 beat with start", 9, 4, 9, 4);
        idle(); idle();

        model_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule